// File: doc/BRIEF.md
# NMI Source Gating Controller

This block gathers the four conditions that must interrupt the processor without regard to its interrupt flag: a memory parity error, an I/O channel check, a bus channel time-out and a watchdog time-out. Each condition is captured in a sticky latch. One global mask bit blocks only the parity and channel-check latches from reaching the NMI request. Each of those two also has its own enable bit, and it is captured only while that enable is set. The time-out and watchdog latches always reach the NMI request. Only a system reset clears them.

Every new NMI also raises a bus-arbitration hold. The hold stays up until software writes a 0 to the hold bit of the arbitration register. A plain register port gives software access to three registers. The mask register is write-only and also forwards a 7-bit index to an external RAM. The control port holds the enables, returns the latch states and a refresh toggle, and fires a timer-0 latch clear. The arbitration register releases the hold. The register port has no back-pressure: a write takes effect at the clock edge where `io_wr` is high, and read data is combinational while `io_rd` is high.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released: `nmi_o`=0, `arb_hold_o`=0, `tmr0_clr_o`=0, `cmos_idx_o`=0, the mask is 1, both enables are 0, all latches are 0, and a control-port read returns 0x00.
- R2: A write to address 0x0061 sets the parity enable from data bit 2 and the channel-check enable from data bit 3. A parity or channel-check input that is high at a clock edge while its enable is 1 sets its latch at that edge. While the enable is 0 the input is ignored. A control-port read returns the parity latch in bit 7, the channel-check latch in bit 6, the parity enable in bit 2 and the channel-check enable in bit 3.
- R3: Bit 7 of a write to address 0x0070 is the mask. While it is 1, the parity and channel-check latches do not drive `nmi_o`, and they keep their state. While it is 0, a set latch drives `nmi_o` high.
- R4: A high time-out or watchdog input sets its latch at that edge. From then on it drives `nmi_o` regardless of the mask and the enables. Only reset clears it.
- R5: A control-port write that clears an enable clears that source's latch at the same edge.
- R6: `arb_hold_o` rises one clock after `nmi_o` rises. It stays high until a write to address 0x0090 with data bit 6 = 0. A write with bit 6 = 1 has no effect. When a rise of `nmi_o` and a release fall on the same edge, the hold is set. A read of 0x0090 returns the hold in bit 6.
- R7: Bit 4 of a control-port read flips once for each clock edge at which `refresh_req_i` is high. It starts at 0.
- R8: A control-port write with data bit 7 = 1 drives `tmr0_clr_o` high for exactly the one cycle after the write edge.
- R9: Bits 6..0 of a write to 0x0070 appear on `cmos_idx_o` after the write edge.
- R10: `io_rdata` is 0 when `io_rd` is low, when reading the write-only address 0x0070, and when reading an unmapped address.
- R11: `nmi_o` is high whenever any latch that is not blocked by the mask is set, so several sources combine into one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_addr | input | 16 | Register address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| par_err_i | input | 1 | Memory parity error |
| chan_chk_i | input | 1 | I/O channel check |
| chan_tmo_i | input | 1 | Bus channel time-out |
| wdt_tmo_i | input | 1 | Watchdog time-out |
| refresh_req_i | input | 1 | Refresh request, one per high cycle |
| nmi_o | output | 1 | NMI request to the processor |
| arb_hold_o | output | 1 | Bus arbitration hold |
| cmos_idx_o | output | 7 | Index forwarded from mask-register writes |
| tmr0_clr_o | output | 1 | One-cycle timer-0 latch clear |

## Verification
The properties assume that every source input and register strobe is synchronous to `clk` and stable around the rising edge. They also assume that at most one register access occurs per cycle, which is why the release and arbitration properties can decode the address alone. The stimulus drives all inputs on the falling edge, uses single-cycle strobes, and leaves each source pulse high for one edge only. This keeps every latch set and every hold rise attributable to exactly one step.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = DATA_W - 1;
  localparam int NUM_SRC = 4;

  // Source index order inside every source vector
  typedef enum int unsigned {
    SRC_PAR = 0,
    SRC_CHK = 1,
    SRC_TMO = 2,
    SRC_WDT = 3
  } nmi_src_e;

  // Sources subject to the global mask and to a software enable
  localparam logic [NUM_SRC-1:0] GATED_SRC = 4'b0011;

  // Bit positions decoded by software
  localparam int MASK_BIT     = 7;
  localparam int PB_TMR0_BIT  = 7;
  localparam int PB_PAR_EN    = 2;
  localparam int PB_CHK_EN    = 3;
  localparam int PB_PAR_LAT   = 7;
  localparam int PB_CHK_LAT   = 6;
  localparam int PB_RFSH_BIT  = 4;
  localparam int ARB_HOLD_BIT = 6;
endpackage

// File: rtl/nmi_io_regs.sv
module nmi_io_regs
  import nmi_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0070,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 16'h0061,
  parameter logic [ADDR_W-1:0] ARB_ADDR   = 16'h0090
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic               refresh_req_i,
  output logic               mask_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_nxt,
  output logic               rfsh_tgl_q,
  output logic [IDX_W-1:0]   cmos_idx_o,
  output logic               tmr0_clr_o,
  output logic               arb_rel_o
);
  localparam logic [NUM_SRC-1:0] EN_RST = ~GATED_SRC;

  logic wr_mask, wr_pb, wr_arb;

  assign wr_mask = io_wr && (io_addr == MASK_ADDR);
  assign wr_pb   = io_wr && (io_addr == PORTB_ADDR);
  assign wr_arb  = io_wr && (io_addr == ARB_ADDR);

  assign arb_rel_o = wr_arb && !io_wdata[ARB_HOLD_BIT];

  // Next enable value, so a latch clears on the same edge as its enable
  always_comb begin
    en_nxt = en_q;
    if (wr_pb) begin
      en_nxt[SRC_PAR] = io_wdata[PB_PAR_EN];
      en_nxt[SRC_CHK] = io_wdata[PB_CHK_EN];
    end
    en_nxt = en_nxt | ~GATED_SRC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= 1'b1;
      en_q       <= EN_RST;
      cmos_idx_o <= '0;
      tmr0_clr_o <= 1'b0;
      rfsh_tgl_q <= 1'b0;
    end else begin
      en_q       <= en_nxt;
      tmr0_clr_o <= wr_pb && io_wdata[PB_TMR0_BIT];
      if (wr_mask) begin
        mask_q     <= io_wdata[MASK_BIT];
        cmos_idx_o <= io_wdata[IDX_W-1:0];
      end
      if (refresh_req_i) rfsh_tgl_q <= ~rfsh_tgl_q;
    end
  end
endmodule

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic en_i,
  output logic lat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= en_i & (lat_q | src_i);
  end
endmodule

// File: rtl/nmi_arb_hold.sv
module nmi_arb_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic rel_i,
  output logic hold_q
);
  logic nmi_d_q;
  logic nmi_rise;

  assign nmi_rise = nmi_i && !nmi_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      nmi_d_q <= nmi_i;
      if (nmi_rise)   hold_q <= 1'b1;
      else if (rel_i) hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
  import nmi_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0070,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 16'h0061,
  parameter logic [ADDR_W-1:0] ARB_ADDR   = 16'h0090
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              par_err_i,
  input  logic              chan_chk_i,
  input  logic              chan_tmo_i,
  input  logic              wdt_tmo_i,
  input  logic              refresh_req_i,
  output logic              nmi_o,
  output logic              arb_hold_o,
  output logic [6:0]        cmos_idx_o,
  output logic              tmr0_clr_o
);
  logic               mask_q;
  logic [NUM_SRC-1:0] en_q, en_nxt;
  logic [NUM_SRC-1:0] src_vec, lat_q, qual;
  logic               rfsh_tgl_q;
  logic               arb_rel;

  nmi_io_regs #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR),
    .PORTB_ADDR(PORTB_ADDR), .ARB_ADDR(ARB_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .refresh_req_i(refresh_req_i),
    .mask_q(mask_q), .en_q(en_q), .en_nxt(en_nxt),
    .rfsh_tgl_q(rfsh_tgl_q), .cmos_idx_o(cmos_idx_o),
    .tmr0_clr_o(tmr0_clr_o), .arb_rel_o(arb_rel)
  );

  always_comb begin
    src_vec = '0;
    src_vec[SRC_PAR] = par_err_i;
    src_vec[SRC_CHK] = chan_chk_i;
    src_vec[SRC_TMO] = chan_tmo_i;
    src_vec[SRC_WDT] = wdt_tmo_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    nmi_src_latch u_lat (
      .clk(clk), .rst_n(rst_n), .src_i(src_vec[g]),
      .en_i(en_nxt[g]), .lat_q(lat_q[g])
    );
    if (GATED_SRC[g]) begin : g_masked
      assign qual[g] = lat_q[g] & ~mask_q;
    end else begin : g_open
      assign qual[g] = lat_q[g];
    end
  end

  assign nmi_o = |qual;

  nmi_arb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_o),
    .rel_i(arb_rel), .hold_q(arb_hold_o)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == PORTB_ADDR) begin
        io_rdata[PB_PAR_LAT]  = lat_q[SRC_PAR];
        io_rdata[PB_CHK_LAT]  = lat_q[SRC_CHK];
        io_rdata[PB_RFSH_BIT] = rfsh_tgl_q;
        io_rdata[PB_PAR_EN]   = en_q[SRC_PAR];
        io_rdata[PB_CHK_EN]   = en_q[SRC_CHK];
      end else if (io_addr == ARB_ADDR) begin
        io_rdata[ARB_HOLD_BIT] = arb_hold_o;
      end
    end
  end
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 16'h0061,
  parameter logic [ADDR_W-1:0] ARB_ADDR   = 16'h0090
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              chan_tmo_i,
  input logic              wdt_tmo_i,
  input logic              nmi_o,
  input logic              arb_hold_o,
  input logic              tmr0_clr_o,
  input logic              mask_q,
  input logic [3:0]        lat_q
);
  AST_WDT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo_i |=> nmi_o);  // R4
  AST_TMO_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_tmo_i |=> nmi_o);  // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && $past(mask_q) && !$past(nmi_o) && !$past(chan_tmo_i) && !$past(wdt_tmo_i)) |-> !nmi_o);  // R3
  AST_HOLD_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |=> arb_hold_o);  // R6
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_hold_o && !(io_wr && io_addr == ARB_ADDR && !io_wdata[6])) |=> arb_hold_o);  // R6
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORTB_ADDR && !io_wdata[2]) |=> !lat_q[0]);  // R5
  AST_TMR0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_clr_o |-> $past(io_wr && io_addr == PORTB_ADDR && io_wdata[7]));  // R8
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));  // R10
endmodule

bind nmi_gate_ctrl nmi_gate_chk #(
  .ADDR_W(ADDR_W), .PORTB_ADDR(PORTB_ADDR), .ARB_ADDR(ARB_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
  .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .chan_tmo_i(chan_tmo_i), .wdt_tmo_i(wdt_tmo_i), .nmi_o(nmi_o),
  .arb_hold_o(arb_hold_o), .tmr0_clr_o(tmr0_clr_o),
  .mask_q(mask_q), .lat_q(lat_q)
);

// File: tb/nmi_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module nmi_gate_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        par_err_i = 0, chan_chk_i = 0, chan_tmo_i = 0, wdt_tmo_i = 0;
  logic        refresh_req_i = 0;
  logic        nmi_o, arb_hold_o, tmr0_clr_o;
  logic [6:0]  cmos_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nmi_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .par_err_i(par_err_i), .chan_chk_i(chan_chk_i),
    .chan_tmo_i(chan_tmo_i), .wdt_tmo_i(wdt_tmo_i),
    .refresh_req_i(refresh_req_i), .nmi_o(nmi_o),
    .arb_hold_o(arb_hold_o), .cmos_idx_o(cmos_idx_o),
    .tmr0_clr_o(tmr0_clr_o)
  );

  // Step: {wr, addr, wdata, src{wdt,tmo,chk,par}, exp_nmi, exp_hold, exp_portb}
  localparam int NSTEP = 12;
  localparam logic [38:0] STEPS [NSTEP] = '{
    {1'b1, 16'h0061, 8'h0C, 4'b0000, 1'b0, 1'b0, 8'h0C},  // R2 enables on
    {1'b0, 16'h0000, 8'h00, 4'b0001, 1'b0, 1'b0, 8'h8C},  // R3 parity latched, masked
    {1'b1, 16'h0070, 8'h05, 4'b0000, 1'b1, 1'b0, 8'h8C},  // R3 unmask
    {1'b0, 16'h0000, 8'h00, 4'b0000, 1'b1, 1'b1, 8'h8C},  // R6 hold rises
    {1'b1, 16'h0090, 8'h40, 4'b0000, 1'b1, 1'b1, 8'h8C},  // R6 bit6=1 ignored
    {1'b1, 16'h0090, 8'h00, 4'b0000, 1'b1, 1'b0, 8'h8C},  // R6 release
    {1'b1, 16'h0061, 8'h08, 4'b0000, 1'b0, 1'b0, 8'h08},  // R5 enable clear
    {1'b0, 16'h0000, 8'h00, 4'b0010, 1'b1, 1'b0, 8'h48},  // R2 channel check
    {1'b1, 16'h0070, 8'h80, 4'b0000, 1'b0, 1'b1, 8'h48},  // R3 mask again
    {1'b1, 16'h0090, 8'h00, 4'b0000, 1'b0, 1'b0, 8'h48},  // R6 release
    {1'b0, 16'h0000, 8'h00, 4'b1000, 1'b1, 1'b0, 8'h48},  // R4 watchdog masked-free
    {1'b1, 16'h0061, 8'h00, 4'b0000, 1'b1, 1'b1, 8'h00}   // R11 chk gone, wdt stays
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] addr,
                      input logic [7:0] data, input logic [3:0] src);
    @(negedge clk);
    io_wr = wr; io_addr = addr; io_wdata = data;
    {wdt_tmo_i, chan_tmo_i, chan_chk_i, par_err_i} = src;
    @(posedge clk);
    #1;
    io_wr = 1'b0; io_wdata = '0;
    {wdt_tmo_i, chan_tmo_i, chan_chk_i, par_err_i} = '0;
  endtask

  task automatic rd(input logic [15:0] addr, output logic [7:0] val);
    io_rd = 1'b1; io_addr = addr;
    #1 val = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    do_reset();
    #1;
    check("R1 nmi", nmi_o, 0);
    check("R1 hold", arb_hold_o, 0);
    check("R1 idx", cmos_idx_o, 0);
    check("R1 tmr0", tmr0_clr_o, 0);
    rd(16'h0061, v); check("R1 portb", v, 8'h00);
    rd(16'h0090, v); check("R1 arb", v, 8'h00);

    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i][38], STEPS[i][37:22], STEPS[i][21:14], STEPS[i][13:10]);
      check($sformatf("R11 step %0d nmi", i), nmi_o, STEPS[i][9]);
      check($sformatf("R6 step %0d hold", i), arb_hold_o, STEPS[i][8]);
      rd(16'h0061, v);
      check($sformatf("R2 step %0d portb", i), v, STEPS[i][7:0]);
    end

    // R7 refresh toggle
    do_reset();
    @(negedge clk); refresh_req_i = 1'b1;
    repeat (3) @(negedge clk);
    refresh_req_i = 1'b0;
    rd(16'h0061, v); check("R7 toggle odd", v, 8'h10);
    @(negedge clk); refresh_req_i = 1'b1;
    @(negedge clk); refresh_req_i = 1'b0;
    rd(16'h0061, v); check("R7 toggle even", v, 8'h00);

    // R8 timer-0 clear pulse
    step(1'b1, 16'h0061, 8'h80, 4'b0000);
    check("R8 pulse high", tmr0_clr_o, 1);
    @(posedge clk); #1;
    check("R8 pulse low", tmr0_clr_o, 0);

    // R9 / R10 index forwarding and reads
    step(1'b1, 16'h0070, 8'h2A, 4'b0000);
    check("R9 idx", cmos_idx_o, 7'h2A);
    rd(16'h0070, v); check("R10 write-only read", v, 8'h00);
    rd(16'h1234, v); check("R10 unmapped read", v, 8'h00);

    // R2 disabled source ignored while unmasked
    step(1'b0, 16'h0000, 8'h00, 4'b0001);
    check("R2 disabled par nmi", nmi_o, 0);
    rd(16'h0061, v); check("R2 disabled par latch", v, 8'h00);

    // R4 time-out ignores mask and enables, reset clears (R1)
    do_reset();
    step(1'b0, 16'h0000, 8'h00, 4'b0100);
    check("R4 tmo nmi", nmi_o, 1);
    step(1'b1, 16'h0070, 8'h80, 4'b0000);
    step(1'b1, 16'h0061, 8'h00, 4'b0000);
    check("R4 tmo stays", nmi_o, 1);
    do_reset();
    #1;
    check("R1 reset clears nmi", nmi_o, 0);

    // R6 set wins over same-edge release
    step(1'b0, 16'h0000, 8'h00, 4'b0100);
    step(1'b1, 16'h0090, 8'h00, 4'b0000);
    check("R6 set wins", arb_hold_o, 1);
    rd(16'h0090, v); check("R6 arb read", v, 8'h40);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule